// File: doc/BRIEF.md
# ATAPI Packet Handshake Sequencer

This block runs the device side of the ATAPI packet handshake so that the firmware only has to set up registers and then deal with exceptions. Three sequences are built in. The first takes in the twelve command bytes of a packet command and stores them in a small command buffer. The second asserts the data-request flag and counts words for PIO or DMA data blocks. The third writes the completion status at the end of a transfer. The block drives the busy, data-request and check status flags, and it keeps the transfer counter and the packet-size value.

A byte-wide register port sets the enables. It also provides a strobe that flushes the command buffer, a strobe that clears the counters, a suspend bit, a one-shot repeat of packet reception, and a mode that unmasks the data-transfer-end event. In that mode the sequencer stops so the firmware can reconfigure. A sequence starts only on a single-cycle start pulse.

Top module: `pkt_seq_top`

## Requirements
- R1: After reset the state code is 0 (idle), busy, data-request and check are low, the command pointer is 0 and the control register reads 0.
- R2: Control address 0 bit 0 enables packet capture. A start pulse in idle enters state 1 with data-request high and resets the pointer to 0. Each valid byte is stored at the pointer. The twelfth byte returns the block to idle, sets the buffer-full output, and clears bit 0 and bit 5. Bytes offered outside state 1 are ignored.
- R3: Writing 1 to bit 0 at address 1 zeroes the command pointer on the next edge. This takes precedence over a byte arriving in the same cycle, which is discarded.
- R4: Bit 1 enables data requests. A start pulse with a nonzero count enters state 2 (data-request high). The data is split into blocks of packet size words, or of all remaining words when the packet size is 0 or larger than the remainder. Each word pulse decrements the count. Blocks are separated by one cycle in state 3 with busy high and data-request low.
- R5: With bit 2 set, the last word leads to one cycle in state 5 with busy high. In that cycle the check flag is loaded from bit 3 and the block then returns to idle. Bit 2 on its own, without bit 1, leaves a start pulse with no effect.
- R6: Bit 4 freezes the state, the counters and the completion write. A completion held this way writes the check flag only after bit 4 is cleared.
- R7: When a data-request sequence or a completion sequence ends, bit 5 (repeat) is copied into bit 0. Bit 5 is cleared when the next packet capture ends.
- R8: With bit 6 set, a data-transfer-end event in state 2 moves the block to state 4 (busy high, data-request low) and latches the event flag. Clearing bit 6 returns the block to state 2 and clears the flag. With bit 6 clear, the event leaves state 2 unchanged.
- R9: Writing 1 to bit 1 at address 1 zeroes the transfer count and the packet size. This takes precedence over a same-cycle word decrement.
- R10: Reads return the control bits at address 0 and 0 at address 1 (strobes). Address 2 returns the packet size and address 3 returns the live transfer count. Writes to addresses 2 and 3 load those values.
- R11: Clearing the enable of the active sequence returns the block to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| start_i | input | 1 | Single-cycle sequence start |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_byte_i | input | 8 | Command byte from host |
| cmd_rd_idx_i | input | 4 | Command buffer read index |
| cmd_rd_byte_o | output | 8 | Command buffer read data |
| cmd_ptr_o | output | 4 | Command buffer write pointer |
| cmd_full_o | output | 1 | All twelve bytes received |
| word_xfer_i | input | 1 | One data word transferred |
| dtei_i | input | 1 | Data-transfer-end event |
| bsy_o | output | 1 | Busy status flag |
| drq_o | output | 1 | Data-request status flag |
| chk_o | output | 1 | Check status flag |
| dtei_flag_o | output | 1 | Latched data-transfer-end event |
| seq_state_o | output | 3 | Sequencer state code |

## Verification
Two pairs of functions can act in the same cycle. A flush strobe can coincide with an incoming command byte, and a clear strobe can coincide with a word decrement. The bench drives each pair in a single cycle. It judges the flush case by the pointer reading 0 and by the first byte of the following capture, and the clear case by the count reading 0. A third case sets suspend in the same cycle as the last word. That completion must then stay pending, with the check flag unchanged, until suspend is released.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PKT  = 3'd1,
    ST_DATA = 3'd2,
    ST_GAP  = 3'd3,
    ST_HALT = 3'd4,
    ST_CMPL = 3'd5
  } seq_st_e;

  typedef struct packed {
    logic rsv;
    logic unmask;
    logic rpt;
    logic hold;
    logic err;
    logic cmpl_en;
    logic drq_en;
    logic pkt_en;
  } ctrl_t;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STRB = 2'd1;
  localparam logic [1:0] ADR_SIZE = 2'd2;
  localparam logic [1:0] ADR_CNT  = 2'd3;
endpackage

// File: rtl/pkt_seq_regs.sv
module pkt_seq_regs
  import pkt_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 pkt_done_i,
  input  logic                 rearm_i,
  output ctrl_t                ctrl_o,
  output logic [CNT_W-1:0]     pkt_size_o,
  output logic                 flush_o,
  output logic                 clr_o,
  output logic                 cnt_ld_o
);
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] size_q;

  assign flush_o  = we_i && (addr_i == ADR_STRB) && wdata_i[0];
  assign clr_o    = we_i && (addr_i == ADR_STRB) && wdata_i[1];
  assign cnt_ld_o = we_i && (addr_i == ADR_CNT);

  // firmware write wins over sequencer updates in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i && addr_i == ADR_CTRL) begin
      ctrl_q     <= ctrl_t'(wdata_i);
      ctrl_q.rsv <= 1'b0;
    end else if (pkt_done_i) begin
      ctrl_q.pkt_en <= 1'b0;
      ctrl_q.rpt    <= 1'b0;
    end else if (rearm_i) begin
      ctrl_q.pkt_en <= ctrl_q.rpt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          size_q <= '0;
    else if (clr_o)                       size_q <= '0;
    else if (we_i && addr_i == ADR_SIZE)  size_q <= wdata_i[CNT_W-1:0];
  end

  assign ctrl_o     = ctrl_q;
  assign pkt_size_o = size_q;
endmodule

// File: rtl/pkt_seq_cmdfifo.sv
module pkt_seq_cmdfifo #(
  parameter int DEPTH = 12,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             restart_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W-1:0]     rdata_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [W-1:0]     mem_q [DEPTH];
  logic             wr_ok;

  assign full_o = (ptr_q == PTR_W'(DEPTH));
  assign wr_ok  = wr_i && !flush_i && !restart_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ptr_q <= '0;
    else if (flush_i || restart_i) ptr_q <= '0;
    else if (wr_ok)               ptr_q <= ptr_q + PTR_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (wr_ok && ptr_q == PTR_W'(g))     mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (rd_idx_i <= MAX_IDX) ? mem_q[rd_idx_i] : '0;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/pkt_seq_fsm.sv
module pkt_seq_fsm
  import pkt_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DEPTH = 12,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_en_i,
  input  logic             drq_en_i,
  input  logic             cmpl_en_i,
  input  logic             err_i,
  input  logic             hold_i,
  input  logic             unmask_i,
  input  logic [CNT_W-1:0] pkt_size_i,
  input  logic             start_i,
  input  logic             cmd_valid_i,
  input  logic             flush_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             word_i,
  input  logic             dtei_i,
  input  logic             clr_i,
  input  logic             cnt_ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output seq_st_e          state_o,
  output logic [CNT_W-1:0] xfer_cnt_o,
  output logic             fifo_wr_o,
  output logic             fifo_restart_o,
  output logic             pkt_done_o,
  output logic             rearm_o,
  output logic             bsy_o,
  output logic             drq_o,
  output logic             chk_o,
  output logic             dtei_flag_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  seq_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, blk_q, blk_ld_val;
  logic chk_q, flag_q;
  logic dec, blk_ld, chk_wr, flag_clr;

  assign blk_ld_val = (pkt_size_i == '0 || pkt_size_i > cnt_q) ? cnt_q : pkt_size_i;

  always_comb begin
    st_d = st_q;
    fifo_wr_o = 1'b0; fifo_restart_o = 1'b0;
    pkt_done_o = 1'b0; rearm_o = 1'b0;
    dec = 1'b0; blk_ld = 1'b0; chk_wr = 1'b0; flag_clr = 1'b0;
    if (!hold_i) begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (pkt_en_i) begin
            st_d = ST_PKT; fifo_restart_o = 1'b1;
          end else if (drq_en_i) begin
            if (cnt_q == '0) begin
              st_d = cmpl_en_i ? ST_CMPL : ST_IDLE; rearm_o = !cmpl_en_i;
            end else begin
              st_d = ST_DATA; blk_ld = 1'b1;
            end
          end
        end
        ST_PKT: begin
          if (!pkt_en_i) st_d = ST_IDLE;
          else if (cmd_valid_i && !flush_i) begin
            fifo_wr_o = 1'b1;
            if (ptr_i == LAST) begin
              st_d = ST_IDLE; pkt_done_o = 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (!drq_en_i) st_d = ST_IDLE;
          else if (dtei_i && unmask_i) st_d = ST_HALT;
          else if (word_i) begin
            dec = 1'b1;
            if (blk_q == CNT_W'(1)) begin
              if (cnt_q == CNT_W'(1)) begin
                st_d = cmpl_en_i ? ST_CMPL : ST_IDLE; rearm_o = !cmpl_en_i;
              end else st_d = ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (!drq_en_i) st_d = ST_IDLE;
          else begin st_d = ST_DATA; blk_ld = 1'b1; end
        end
        ST_HALT: begin
          if (!drq_en_i) begin st_d = ST_IDLE; flag_clr = 1'b1; end
          else if (!unmask_i) begin st_d = ST_DATA; flag_clr = 1'b1; end
        end
        ST_CMPL: begin
          chk_wr = 1'b1; rearm_o = 1'b1; st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; blk_q <= '0; chk_q <= 1'b0; flag_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (clr_i)         cnt_q <= '0;
      else if (cnt_ld_i) cnt_q <= ld_val_i;
      else if (dec)      cnt_q <= cnt_q - CNT_W'(1);
      if (blk_ld)        blk_q <= blk_ld_val;
      else if (dec)      blk_q <= blk_q - CNT_W'(1);
      if (chk_wr)        chk_q <= err_i;
      flag_q <= (flag_q && !flag_clr) || dtei_i;
    end
  end

  assign state_o     = st_q;
  assign xfer_cnt_o  = cnt_q;
  assign bsy_o       = (st_q == ST_GAP) || (st_q == ST_HALT) || (st_q == ST_CMPL);
  assign drq_o       = (st_q == ST_PKT) || (st_q == ST_DATA);
  assign chk_o       = chk_q;
  assign dtei_flag_o = flag_q;
endmodule

// File: rtl/pkt_seq_top.sv
module pkt_seq_top
  import pkt_seq_pkg::*;
#(
  parameter int CMD_BYTES = 12,
  parameter int CNT_W     = 8,
  localparam int PTR_W = $clog2(CMD_BYTES + 1),
  localparam int IDX_W = $clog2(CMD_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             start_i,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_byte_i,
  input  logic [IDX_W-1:0] cmd_rd_idx_i,
  output logic [7:0]       cmd_rd_byte_o,
  output logic [PTR_W-1:0] cmd_ptr_o,
  output logic             cmd_full_o,
  input  logic             word_xfer_i,
  input  logic             dtei_i,
  output logic             bsy_o,
  output logic             drq_o,
  output logic             chk_o,
  output logic             dtei_flag_o,
  output logic [2:0]       seq_state_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] pkt_size, xfer_cnt;
  logic             flush, clr, cnt_ld, pkt_done, rearm, fifo_wr, fifo_restart;
  seq_st_e          state;

  pkt_seq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .pkt_done_i(pkt_done), .rearm_i(rearm), .ctrl_o(ctrl_q), .pkt_size_o(pkt_size),
    .flush_o(flush), .clr_o(clr), .cnt_ld_o(cnt_ld)
  );

  pkt_seq_cmdfifo #(.DEPTH(CMD_BYTES), .W(8)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .restart_i(fifo_restart), .wr_i(fifo_wr),
    .wdata_i(cmd_byte_i), .rd_idx_i(cmd_rd_idx_i), .rdata_o(cmd_rd_byte_o),
    .ptr_o(cmd_ptr_o), .full_o(cmd_full_o)
  );

  pkt_seq_fsm #(.CNT_W(CNT_W), .DEPTH(CMD_BYTES)) u_fsm (
    .clk_i, .rst_ni,
    .pkt_en_i(ctrl_q.pkt_en), .drq_en_i(ctrl_q.drq_en), .cmpl_en_i(ctrl_q.cmpl_en),
    .err_i(ctrl_q.err), .hold_i(ctrl_q.hold), .unmask_i(ctrl_q.unmask),
    .pkt_size_i(pkt_size), .start_i, .cmd_valid_i, .flush_i(flush), .ptr_i(cmd_ptr_o),
    .word_i(word_xfer_i), .dtei_i, .clr_i(clr), .cnt_ld_i(cnt_ld),
    .ld_val_i(reg_wdata_i[CNT_W-1:0]), .state_o(state), .xfer_cnt_o(xfer_cnt),
    .fifo_wr_o(fifo_wr), .fifo_restart_o(fifo_restart), .pkt_done_o(pkt_done),
    .rearm_o(rearm), .bsy_o, .drq_o, .chk_o, .dtei_flag_o
  );

  assign seq_state_o = state;

  always_comb begin
    unique case (reg_addr_i)
      ADR_CTRL: reg_rdata_o = ctrl_q;
      ADR_SIZE: reg_rdata_o = REG_W'(pkt_size);
      ADR_CNT:  reg_rdata_o = REG_W'(xfer_cnt);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pkt_seq_chk.sv
module pkt_seq_chk #(
  parameter int PTR_W = 4,
  parameter int CNT_W = 8,
  parameter int DEPTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic             hold_i,
  input logic             err_i,
  input logic             unmask_i,
  input logic             drq_en_i,
  input logic             dtei_i,
  input logic [2:0]       seq_state_o,
  input logic             bsy_o,
  input logic             drq_o,
  input logic             chk_o,
  input logic [PTR_W-1:0] cmd_ptr_o,
  input logic [CNT_W-1:0] xfer_cnt_i,
  input logic [CNT_W-1:0] pkt_size_i
);
  a_r6_hold_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(seq_state_o));
  a_r6_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(chk_o));
  a_r3_flush_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd1 && reg_wdata_i[0]) |=> (cmd_ptr_o == '0));
  a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd1 && reg_wdata_i[1]) |=> (xfer_cnt_i == '0 && pkt_size_i == '0));
  a_r4_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bsy_o && drq_o));
  a_r5_chk_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state_o == 3'd5 && !hold_i) |=> (chk_o == $past(err_i)));
  a_r8_halt_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state_o == 3'd2 && dtei_i && unmask_i && drq_en_i && !hold_i) |=> (seq_state_o == 3'd4));
  a_r2_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ptr_o <= PTR_W'(DEPTH));
endmodule

bind pkt_seq_top pkt_seq_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W), .DEPTH(CMD_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .hold_i(ctrl_q.hold), .err_i(ctrl_q.err),
  .unmask_i(ctrl_q.unmask), .drq_en_i(ctrl_q.drq_en), .dtei_i(dtei_i),
  .seq_state_o(seq_state_o), .bsy_o(bsy_o), .drq_o(drq_o), .chk_o(chk_o),
  .cmd_ptr_o(cmd_ptr_o), .xfer_cnt_i(xfer_cnt), .pkt_size_i(pkt_size)
);

// File: tb/pkt_seq_top_tb_top.sv
module pkt_seq_top_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 0; logic [1:0] reg_addr_i = 0; logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic start_i = 0, cmd_valid_i = 0; logic [7:0] cmd_byte_i = 0;
  logic [3:0] cmd_rd_idx_i = 0; logic [7:0] cmd_rd_byte_o;
  logic [3:0] cmd_ptr_o; logic cmd_full_o;
  logic word_xfer_i = 0, dtei_i = 0;
  logic bsy_o, drq_o, chk_o, dtei_flag_o; logic [2:0] seq_state_o;
  int checks = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  pkt_seq_top dut_i (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic pulse_start();
    start_i = 1; step(); start_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int words, gaps, cmpls, eff, exp_gaps, errb, prev;
    step(); step(); rst_ni = 1; step();
    // R1 reset state
    rd(2'd0, v);
    check("R1 state", seq_state_o, 0); check("R1 flags", {bsy_o, drq_o, chk_o}, 0);
    check("R1 ptr", cmd_ptr_o, 0);     check("R1 ctrl", v, 0);

    // R2 packet capture
    wr(2'd0, 8'h01); pulse_start();
    check("R2 enter", seq_state_o, 1); check("R2 drq", drq_o, 1); check("R2 bsy", bsy_o, 0);
    for (int i = 0; i < 12; i++) begin
      cmd_valid_i = 1; cmd_byte_i = 8'(i * 37 + 5); step();
    end
    cmd_valid_i = 0;
    check("R2 idle", seq_state_o, 0); check("R2 full", cmd_full_o, 1); check("R2 drq off", drq_o, 0);
    rd(2'd0, v); check("R2 en cleared", v[0], 0);
    begin
      int bad = 0;
      for (int i = 0; i < 12; i++) begin
        cmd_rd_idx_i = 4'(i); #1;
        if (cmd_rd_byte_o != 8'(i * 37 + 5)) bad++;
      end
      check("R2 bytes", bad, 0);
    end
    cmd_valid_i = 1; cmd_byte_i = 8'hEE; step(); cmd_valid_i = 0;
    check("R2 ignored outside", cmd_ptr_o, 12);

    // R3 flush vs same-cycle byte
    wr(2'd0, 8'h01); pulse_start();
    check("R3 restart ptr", cmd_ptr_o, 0);
    for (int i = 0; i < 5; i++) begin
      cmd_valid_i = 1; cmd_byte_i = 8'(100 + i); step();
    end
    check("R3 partial", cmd_ptr_o, 5);
    cmd_valid_i = 1; cmd_byte_i = 8'h77; reg_we_i = 1; reg_addr_i = 2'd1; reg_wdata_i = 8'h01;
    step(); reg_we_i = 0; cmd_valid_i = 0;
    check("R3 flush wins", cmd_ptr_o, 0); check("R3 still capturing", seq_state_o, 1);
    for (int i = 0; i < 12; i++) begin
      cmd_valid_i = 1; cmd_byte_i = 8'(200 + i); step();
    end
    cmd_valid_i = 0;
    cmd_rd_idx_i = 0; #1; check("R3 first byte", cmd_rd_byte_o, 200);
    check("R3 done", seq_state_o, 0);

    // R10 readback, strobes read 0
    wr(2'd2, 8'd7); wr(2'd3, 8'd9);
    rd(2'd2, v); check("R10 size", v, 7); rd(2'd3, v); check("R10 count", v, 9);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R10 strobe reads 0", v, 0);

    // R9 clear strobe
    wr(2'd1, 8'h02);
    rd(2'd2, v); check("R9 size zero", v, 0); rd(2'd3, v); check("R9 count zero", v, 0);

    // R5 completion alone has no effect
    wr(2'd0, 8'h04); pulse_start(); check("R5 cmpl without drq", seq_state_o, 0);

    // R4/R5 sweep over packet size and total count
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 6; t++) begin
        errb = (s + t) & 1;
        wr(2'd2, 8'(s)); wr(2'd3, 8'(t)); wr(2'd0, 8'(8'h06 | (errb << 3)));
        pulse_start();
        words = 0; gaps = 0; cmpls = 0;
        for (int k = 0; k < 200; k++) begin
          if (seq_state_o == 3'd0) break;
          if (seq_state_o == 3'd2) words++;
          if (seq_state_o == 3'd3) begin
            gaps++;
            if (!(bsy_o && !drq_o)) check("R4 gap flags", {bsy_o, drq_o}, 2);
          end
          if (seq_state_o == 3'd5) cmpls++;
          word_xfer_i = (seq_state_o == 3'd2);
          step();
        end
        word_xfer_i = 0;
        eff = (s == 0 || s > t) ? t : s;
        exp_gaps = (t == 0) ? 0 : ((t + eff - 1) / eff) - 1;
        check("R4 words", words, t); check("R4 gaps", gaps, exp_gaps);
        check("R5 cmpl cycle", cmpls, 1); check("R5 chk value", chk_o, errb);
        rd(2'd3, v); check("R4 count end", v, 0);
      end
    end

    // R6 suspend set with last word; completion deferred
    prev = chk_o;
    wr(2'd2, 8'd1); wr(2'd3, 8'd1); wr(2'd0, 8'(8'h06 | ((1 - prev) << 3)));
    pulse_start(); check("R6 in data", seq_state_o, 2);
    word_xfer_i = 1; reg_we_i = 1; reg_addr_i = 2'd0; reg_wdata_i = 8'(8'h16 | ((1 - prev) << 3));
    step(); word_xfer_i = 0; reg_we_i = 0;
    step(); step(); step();
    check("R6 frozen state", seq_state_o, 5); check("R6 chk held", chk_o, prev);
    wr(2'd0, 8'(8'h06 | ((1 - prev) << 3)));
    check("R6 still pending", seq_state_o, 5);
    step();
    check("R6 released", seq_state_o, 0); check("R6 chk written", chk_o, 1 - prev);

    // R7 repeat
    wr(2'd2, 8'd1); wr(2'd3, 8'd1); wr(2'd0, 8'h22);
    pulse_start(); word_xfer_i = 1; step(); word_xfer_i = 0;
    rd(2'd0, v); check("R7 rearmed", v[0], 1); check("R7 rpt kept", v[5], 1);
    pulse_start(); check("R7 packet again", seq_state_o, 1);
    for (int i = 0; i < 12; i++) begin
      cmd_valid_i = 1; cmd_byte_i = 8'(i); step();
    end
    cmd_valid_i = 0;
    rd(2'd0, v); check("R7 en off", v[0], 0); check("R7 rpt off", v[5], 0);

    // R8 unmasked dtei halts
    wr(2'd2, 8'd4); wr(2'd3, 8'd4); wr(2'd0, 8'h42);
    pulse_start();
    dtei_i = 1; step(); dtei_i = 0;
    check("R8 halt", seq_state_o, 4); check("R8 flags", {bsy_o, drq_o}, 2);
    check("R8 flag set", dtei_flag_o, 1);
    wr(2'd0, 8'h02); step();
    check("R8 resume", seq_state_o, 2); check("R8 flag clr", dtei_flag_o, 0);
    dtei_i = 1; step(); dtei_i = 0;
    check("R8 masked", seq_state_o, 2);

    // R9 clear beats word decrement
    word_xfer_i = 1; reg_we_i = 1; reg_addr_i = 2'd1; reg_wdata_i = 8'h02;
    step(); word_xfer_i = 0; reg_we_i = 0;
    rd(2'd3, v); check("R9 clear wins", v, 0);

    // R11 enable cleared
    wr(2'd0, 8'h00); step();
    check("R11 idle", seq_state_o, 0); check("R11 drq", drq_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule